// File: doc/BRIEF.md
# Sized Integer ALU with Condition Codes

This block is the integer execute stage of a CISC-style core. Each cycle it can take one operation: an opcode, an operand size (byte, word or longword), a source register index and a destination register index. The source operand can also come from an immediate input. The block combines the destination register value (left operand) with the source value (right operand) and writes the result back into the destination register. Only the bits that belong to the selected size are changed. On the same clock edge it updates a five-bit condition code register.

The flags are always taken at the selected size. Carry comes out of bit 7, 15 or 31. The sign and zero flags come from the sized result. Overflow is judged against the sized signed range. The extend flag keeps the carry of the last arithmetic operation, so a following add-with-extend can chain a multi-precision sum. During such a chain the zero flag can only be cleared, so after the whole chain it shows whether the full wide result is zero. A combinational read port exposes any register.

Top module: `alu_core`

## Requirements
- R1: After reset is asserted (rstN low), all eight data registers and the condition code register read zero.
- R2: Eight 32-bit data registers, numbered 0 to 7, can each serve as source or destination. When useImm is 1, immData replaces the source register. Opcodes: 0 add, 1 subtract (dst - src), 2 add-with-extend, 3 AND, 4 OR, 5 XOR, 6 move, 7 compare.
- R3: Size codes are 0 byte (bits 7:0), 1 word (bits 15:0), and 2 or 3 longword. On a byte or word write, the destination bits above the size keep their old value.
- R4: Add, subtract and add-with-extend produce the result modulo the size. C is the carry out of the size's top bit (for subtract, the borrow). X receives the same value as C.
- R5: For arithmetic operations, V is set exactly when the signed result at the selected size overflows.
- R6: N equals the top bit of the sized result. Z is set when the sized result is all zeros. The one exception to Z is described in R7.
- R7: Add-with-extend adds the current X as a carry-in. It clears Z when the sized result is nonzero and otherwise leaves Z unchanged.
- R8: AND, OR, XOR and move set N and Z from the result and clear V and C. They leave X unchanged. Move copies the sized source value.
- R9: Compare sets N, Z, V and C as subtract does. It writes no register and leaves X unchanged.
- R10: The flags are held as ccr[4]=X, ccr[3]=N, ccr[2]=Z, ccr[1]=V, ccr[0]=C. They and the register write both take effect on the clock edge that accepts the operation. While opValid is low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 3 | Operation select (see R2) |
| opSize | input | 2 | Operand size (see R3) |
| srcSel | input | 3 | Source register index |
| dstSel | input | 3 | Destination register index and left operand |
| useImm | input | 1 | Take the source operand from immData |
| immData | input | 32 | Immediate source operand |
| rdSel | input | 3 | Read port register index |
| rdData | output | 32 | Contents of register rdSel |
| ccr | output | 5 | Condition code register |

## Verification
Two functions meet on every accepted operation and must be judged together: the partial register write-back and the flag update. A byte or word result is correct only if the high bits are preserved in the same cycle as the flags are taken from the sized top bit. Back-to-back add-with-extend operations are the harder case. The X produced on one edge is consumed as carry-in by the next operation while Z is being sticky-cleared. The bench provokes this with chained 32-bit and 64-bit-style sums and with randomly mixed ops issued every cycle. After every edge it compares the destination register and the CCR against a behavioural model that works with wide integers.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;

  localparam int DataW    = 32;
  localparam int NumSizes = 3;
  localparam int FlagW    = 5;

  localparam int FlagC = 0;
  localparam int FlagV = 1;
  localparam int FlagZ = 2;
  localparam int FlagN = 3;
  localparam int FlagX = 4;

  typedef enum logic [2:0] {
    OpAdd  = 3'd0,
    OpSub  = 3'd1,
    OpAddx = 3'd2,
    OpAnd  = 3'd3,
    OpOr   = 3'd4,
    OpXor  = 3'd5,
    OpMove = 3'd6,
    OpCmp  = 3'd7
  } opCode_e;

  typedef enum logic [2:0] {
    FnAdd  = 3'd0,
    FnSub  = 3'd1,
    FnAnd  = 3'd2,
    FnOr   = 3'd3,
    FnXor  = 3'd4,
    FnPass = 3'd5
  } aluFn_e;

  typedef struct packed {
    logic   wrReg;
    logic   wrFlags;
    logic   arith;
    logic   updX;
    logic   useX;
    logic   zSticky;
    aluFn_e fn;
  } ctrlStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_core_pkg::*;
(
  input  logic        opValid,
  input  logic [2:0]  opCode,
  output ctrlStrobe_t strobe
);

  opCode_e op;
  assign op = opCode_e'(opCode);

  always_comb begin
    strobe = '{wrReg: 1'b0, wrFlags: 1'b0, arith: 1'b0, updX: 1'b0,
               useX: 1'b0, zSticky: 1'b0, fn: FnPass};
    if (opValid) begin
      strobe.wrFlags = 1'b1;
      strobe.wrReg   = 1'b1;
      unique case (op)
        OpAdd: begin
          strobe.fn    = FnAdd;
          strobe.arith = 1'b1;
          strobe.updX  = 1'b1;
        end
        OpSub: begin
          strobe.fn    = FnSub;
          strobe.arith = 1'b1;
          strobe.updX  = 1'b1;
        end
        OpAddx: begin
          strobe.fn      = FnAdd;
          strobe.arith   = 1'b1;
          strobe.updX    = 1'b1;
          strobe.useX    = 1'b1;
          strobe.zSticky = 1'b1;
        end
        OpAnd:  strobe.fn = FnAnd;
        OpOr:   strobe.fn = FnOr;
        OpXor:  strobe.fn = FnXor;
        OpMove: strobe.fn = FnPass;
        OpCmp: begin
          strobe.fn    = FnSub;
          strobe.arith = 1'b1;
          strobe.wrReg = 1'b0;
        end
        default: strobe.fn = FnPass;
      endcase
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_core_pkg::*;
#(
  parameter  int NumRegs = 8,
  localparam int RegIdxW = $clog2(NumRegs)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [1:0]         sizeSel,
  input  logic [RegIdxW-1:0] srcSel,
  input  logic [RegIdxW-1:0] dstSel,
  input  logic               useImm,
  input  logic [DataW-1:0]   immData,
  input  logic [RegIdxW-1:0] rdSel,
  output logic [DataW-1:0]   rdData,
  output logic [FlagW-1:0]   ccr
);

  logic [NumRegs-1:0][DataW-1:0] regQ;
  logic [FlagW-1:0]              ccrQ;

  logic [DataW-1:0] opA, opB, opBEff;
  logic             isSub, carryIn;
  logic [1:0]       sizeIdx;

  assign opA     = regQ[dstSel];
  assign opB     = useImm ? immData : regQ[srcSel];
  assign isSub   = (strobe.fn == FnSub);
  assign opBEff  = isSub ? ~opB : opB;
  assign carryIn = isSub ? 1'b1 : (strobe.useX & ccrQ[FlagX]);
  assign sizeIdx = (sizeSel == 2'd3) ? 2'd2 : sizeSel;

  logic [NumSizes-1:0][DataW-1:0] sumBySize;
  logic [NumSizes-1:0][DataW-1:0] maskBySize;
  logic [NumSizes-1:0]            coutBySize;
  logic [NumSizes-1:0]            msbA, msbB, msbR;
  logic [DataW-1:0]               aluRes;

  // One adder slice per operand size; each yields its own carry-out.
  for (genvar gi = 0; gi < NumSizes; gi++) begin : g_size
    localparam int W = 8 << gi;
    logic [W:0] partial;
    assign partial         = {1'b0, opA[W-1:0]} + {1'b0, opBEff[W-1:0]} + {{W{1'b0}}, carryIn};
    assign coutBySize[gi]  = partial[W];
    assign msbA[gi]        = opA[W-1];
    assign msbB[gi]        = opBEff[W-1];
    assign msbR[gi]        = aluRes[W-1];
    if (W == DataW) begin : g_full
      assign sumBySize[gi]  = partial[W-1:0];
      assign maskBySize[gi] = '1;
    end else begin : g_part
      assign sumBySize[gi]  = {{(DataW-W){1'b0}}, partial[W-1:0]};
      assign maskBySize[gi] = {{(DataW-W){1'b0}}, {W{1'b1}}};
    end
  end

  always_comb begin
    unique case (strobe.fn)
      FnAdd, FnSub: aluRes = sumBySize[sizeIdx];
      FnAnd:        aluRes = opA & opB;
      FnOr:         aluRes = opA | opB;
      FnXor:        aluRes = opA ^ opB;
      default:      aluRes = opB;
    endcase
  end

  logic [DataW-1:0] sizeMask, resMasked, writeData;
  logic             signA, signB, signR, resZero, carryFlag, ovfFlag;
  logic [FlagW-1:0] ccrNext;

  assign sizeMask  = maskBySize[sizeIdx];
  assign resMasked = aluRes & sizeMask;
  assign writeData = (opA & ~sizeMask) | resMasked;
  assign signA     = msbA[sizeIdx];
  assign signB     = msbB[sizeIdx];
  assign signR     = msbR[sizeIdx];
  assign resZero   = (resMasked == '0);
  assign carryFlag = coutBySize[sizeIdx] ^ isSub;
  assign ovfFlag   = (signA == signB) && (signR != signA);

  always_comb begin
    ccrNext        = ccrQ;
    ccrNext[FlagN] = signR;
    ccrNext[FlagZ] = strobe.zSticky ? (ccrQ[FlagZ] & resZero) : resZero;
    ccrNext[FlagV] = strobe.arith & ovfFlag;
    ccrNext[FlagC] = strobe.arith & carryFlag;
    if (strobe.updX) ccrNext[FlagX] = carryFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ <= '0;
      ccrQ <= '0;
    end else begin
      if (strobe.wrReg)   regQ[dstSel] <= writeData;
      if (strobe.wrFlags) ccrQ <= ccrNext;
    end
  end

  assign rdData = regQ[rdSel];
  assign ccr    = ccrQ;

  a_r9_quiet_regs: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrReg |=> $stable(regQ));

  a_r10_idle_ccr: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrFlags |=> $stable(ccrQ));

  a_r4_x_tracks_c: assert property (@(posedge clk) disable iff (!rstN)
    strobe.updX |=> ccrQ[FlagX] == ccrQ[FlagC]);

  a_r8_logic_clears_vc: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrFlags && !strobe.arith) |=> ccrQ[FlagV:FlagC] == 2'b00);

  a_r8_x_held: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrFlags && !strobe.updX) |=> ccrQ[FlagX] == $past(ccrQ[FlagX]));

  a_r7_z_never_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.zSticky && !ccrQ[FlagZ]) |=> !ccrQ[FlagZ]);

  a_r3_byte_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrReg && sizeIdx == 2'd0) |=> regQ[$past(dstSel)][DataW-1:8] == $past(opA[DataW-1:8]));

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_core_pkg::*;
#(
  parameter  int NumRegs = 8,
  localparam int RegIdxW = $clog2(NumRegs)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic [2:0]         opCode,
  input  logic [1:0]         opSize,
  input  logic [RegIdxW-1:0] srcSel,
  input  logic [RegIdxW-1:0] dstSel,
  input  logic               useImm,
  input  logic [DataW-1:0]   immData,
  input  logic [RegIdxW-1:0] rdSel,
  output logic [DataW-1:0]   rdData,
  output logic [FlagW-1:0]   ccr
);

  ctrlStrobe_t strobe;

  alu_ctrl i_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobe  (strobe)
  );

  alu_datapath #(.NumRegs(NumRegs)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sizeSel (opSize),
    .srcSel  (srcSel),
    .dstSel  (dstSel),
    .useImm  (useImm),
    .immData (immData),
    .rdSel   (rdSel),
    .rdData  (rdData),
    .ccr     (ccr)
  );

endmodule

// File: tb/test_alu_core.sv
module test_alu_core;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [1:0]  opSize = '0;
  logic [2:0]  srcSel = '0;
  logic [2:0]  dstSel = '0;
  logic        useImm = 1'b0;
  logic [31:0] immData = '0;
  logic [2:0]  rdSel = '0;
  logic [31:0] rdData;
  logic [4:0]  ccr;

  always #5 clk = ~clk;

  alu_core i_alu_core (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opSize(opSize),
    .srcSel(srcSel), .dstSel(dstSel), .useImm(useImm), .immData(immData),
    .rdSel(rdSel), .rdData(rdData), .ccr(ccr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] mReg [8];
  logic [4:0]  mCcr;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: wide integers, explicit widths per size.
  task automatic modelOp(input int op, input int size, input int src, input int dst,
                         input bit useI, input logic [31:0] imm);
    int w;
    longint unsigned mask, a, b, full, res;
    bit c, v, n, zNew, z, x, sa, sb, sr;
    w    = (size == 0) ? 8 : (size == 1) ? 16 : 32;
    mask = (64'd1 << w) - 1;
    a    = longint'(mReg[dst]) & mask;
    b    = longint'(useI ? imm : mReg[src]) & mask;
    x = mCcr[4]; c = 0; v = 0; res = 0;
    sa = (a >> (w-1)) & 1;
    sb = (b >> (w-1)) & 1;
    case (op)
      0, 2: begin
        full = a + b + ((op == 2) ? longint'(x) : 0);
        res  = full & mask;
        c    = ((full >> w) & 1) != 0;
        sr   = (res >> (w-1)) & 1;
        v    = (sa == sb) && (sr != sa);
      end
      1, 7: begin
        res = (a - b) & mask;
        c   = a < b;
        sr  = (res >> (w-1)) & 1;
        v   = (sa != sb) && (sr != sa);
      end
      3: res = a & b;
      4: res = a | b;
      5: res = a ^ b;
      default: res = b;
    endcase
    n    = ((res >> (w-1)) & 1) != 0;
    zNew = (res == 0);
    z    = (op == 2) ? (mCcr[2] && zNew) : zNew;
    if (op <= 2) x = c;
    mCcr = {x, n, z, v, c};
    if (op != 7) mReg[dst] = (mReg[dst] & ~mask[31:0]) | res[31:0];
  endtask

  function automatic string tagFor(input int op);
    case (op)
      0, 1: return "R4";
      2:    return "R7";
      7:    return "R9";
      default: return "R8";
    endcase
  endfunction

  // Issue one op at negedge; it is accepted on the next posedge; check after it.
  task automatic runOp(input int op, input int size, input int src, input int dst,
                       input bit useI, input logic [31:0] imm, input string tag);
    @(negedge clk);
    opValid = 1'b1; opCode = 3'(op); opSize = 2'(size);
    srcSel = 3'(src); dstSel = 3'(dst); useImm = useI; immData = imm;
    modelOp(op, size, src, dst, useI, imm);
    @(posedge clk);
    #1 rdSel = 3'(dst);
    #1;
    check(ccr == mCcr, tag, "ccr", {27'd0, ccr}, {27'd0, mCcr});
    check(rdData == mReg[dst], tag, "dst register", rdData, mReg[dst]);
  endtask

  task automatic idleCycle(input logic [2:0] junkOp);
    @(negedge clk);
    opValid = 1'b0; opCode = junkOp; dstSel = junkOp; srcSel = ~junkOp;
    @(posedge clk);
    #1 rdSel = junkOp;
    #1;
    check(ccr == mCcr, "R10", "ccr while idle", {27'd0, ccr}, {27'd0, mCcr});
    check(rdData == mReg[junkOp], "R10", "register while idle", rdData, mReg[junkOp]);
  endtask

  task automatic scanRegs(input string tag);
    @(negedge clk);
    opValid = 1'b0;
    for (int r = 0; r < 8; r++) begin
      rdSel = 3'(r);
      #1;
      check(rdData == mReg[r], tag, "register scan", rdData, mReg[r]);
    end
  endtask

  initial begin
    for (int r = 0; r < 8; r++) mReg[r] = '0;
    mCcr = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check(ccr == 5'd0, "R1", "ccr after reset", {27'd0, ccr}, 32'd0);
    scanRegs("R1");

    // R2: load every register through move with immediate
    for (int r = 0; r < 8; r++) runOp(6, 2, 0, r, 1'b1, 32'h1111_1111 * (r + 1), "R2");
    runOp(6, 2, 3, 0, 1'b0, 32'h0, "R2");

    // R5: byte signed overflow 0x7F + 0x01
    runOp(6, 2, 0, 1, 1'b1, 32'hABCD_127F, "R2");
    runOp(0, 0, 0, 1, 1'b1, 32'h0000_0001, "R5");
    // R4, R3: byte carry, upper bits kept
    runOp(6, 2, 0, 2, 1'b1, 32'h5555_66FF, "R2");
    runOp(0, 0, 0, 2, 1'b1, 32'h0000_0001, "R3");
    // R4: word borrow
    runOp(6, 2, 0, 3, 1'b1, 32'h9999_0003, "R2");
    runOp(1, 1, 0, 3, 1'b1, 32'h0000_0005, "R4");
    // R5: word overflow on subtract 0x8000 - 1
    runOp(6, 1, 0, 3, 1'b1, 32'h0000_8000, "R3");
    runOp(1, 1, 0, 3, 1'b1, 32'h0000_0001, "R5");
    // R7: 64-bit style chain, low = FFFFFFFF + 1, high = 0 + 0 + X
    runOp(6, 2, 0, 4, 1'b1, 32'hFFFF_FFFF, "R2");
    runOp(6, 2, 0, 5, 1'b1, 32'h0, "R2");
    runOp(0, 2, 0, 4, 1'b1, 32'h1, "R4");
    runOp(2, 2, 0, 5, 1'b1, 32'h0, "R7");
    // R7: zero chain keeps Z set
    runOp(6, 2, 0, 6, 1'b1, 32'h0, "R2");
    runOp(0, 2, 6, 6, 1'b0, 32'h0, "R6");
    runOp(2, 2, 6, 6, 1'b0, 32'h0, "R7");
    runOp(2, 0, 6, 6, 1'b0, 32'h0, "R7");
    // R9: compare leaves register and X
    runOp(0, 2, 0, 7, 1'b1, 32'hFFFF_FFFF, "R4");
    runOp(7, 0, 0, 7, 1'b1, 32'h0000_00FF, "R9");
    runOp(7, 2, 0, 2, 1'b1, 32'h7FFF_FFFF, "R9");
    // R8: logic ops clear V/C, hold X
    runOp(3, 1, 1, 2, 1'b0, 32'h0, "R8");
    runOp(4, 0, 0, 3, 1'b1, 32'h0000_0080, "R8");
    runOp(5, 2, 3, 3, 1'b0, 32'h0, "R8");
    runOp(6, 0, 0, 4, 1'b1, 32'hFFFF_FF80, "R8");
    // R3: size code 3 behaves as longword
    runOp(0, 3, 0, 1, 1'b1, 32'h8000_0000, "R3");
    // R10: idle cycles with garbage on inputs
    idleCycle(3'd7);
    idleCycle(3'd2);
    scanRegs("R2");

    // Mixed random traffic, back-to-back
    for (int i = 0; i < 3000; i++) begin
      int op, sz;
      op = $urandom_range(0, 7);
      sz = $urandom_range(0, 3);
      runOp(op, sz, $urandom_range(0, 7), $urandom_range(0, 7), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom(), (sz < 2 && op != 7) ? "R3" : tagFor(op));
      if (i % 200 == 199) begin
        idleCycle(3'($urandom_range(0, 7)));
        scanRegs("R6");
      end
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

endmodule